// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

The controller collects eight level-sensitive interrupt requests, resolves them by fixed priority (input 0 wins), and signals the processor on a single interrupt output. A byte-wide register port with two addresses carries the traffic. Address 0 is the command location and address 1 is the data location. Writes and reads are strobed and are sampled on the rising clock edge.

A command byte of 0x11 starts configuration. The next three data writes supply, in this order, the vector base, the cascade word and the mode word. The cascade word is kept as a bit mask on a master (`IS_MASTER = 1`). On a slave it is kept as a 3-bit input index. It is exposed as a configuration output and drives no other logic.

When the processor pulses the acknowledge input, the controller returns a vector in the next cycle and records the winning input as in service. Specific end-of-interrupt commands later retire in-service bits. In automatic end-of-interrupt mode nothing is recorded in the in-service register.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, the mask register reads 0xFF at the data address and command reads return the request register. The interrupt output is low and the vector output is 0x00.
- R2: A command write of 0x11 clears the in-service register, clears the mask register to 0x00, selects request-register reads, and begins configuration. The next three data writes load the vector base (bits 7..3 kept), the cascade word and the mode word.
- R3: Until the mode word has been written, the interrupt output stays low and data writes are ignored. A data write in that window leaves the mask at its previous value.
- R4: A master keeps the cascade word whole. A slave keeps only bits 2..0 as an index and zeroes bits 7..3.
- R5: Once configured, data writes load the mask register and data reads return it. A 1 in bit n stops input n from raising the interrupt output.
- R6: Command 0x0B selects the in-service register for command-address reads, and command 0x0A selects the request register. `rdata` updates on the edge where `rd_en` is high and holds otherwise.
- R7: Input 0 has the highest priority. The interrupt output is high only when the highest-priority unmasked request has a lower index than every in-service bit.
- R8: An acknowledge while the interrupt output is high returns {base[7:3], n} for winning input n. When mode-word bit 1 is 0, it also sets in-service bit n.
- R9: When mode-word bit 1 is 1 (automatic end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R10: Command 0x60+n (n = 0..7) clears in-service bit n and no other bit.
- R11: An acknowledge while the interrupt output is low returns {base[7:3], 3'b111} and changes no in-service bit.
- R12: The request register samples the inputs every cycle. When a request is removed, the interrupt output falls one edge later.
- R13: A mask of 0xFF keeps the interrupt output low for any request pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | 0 = command location, 1 = data location |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_in | input | 8 | Level-sensitive interrupt requests |
| inta | input | 1 | Acknowledge pulse, one cycle |
| int_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector captured at the last acknowledge |
| casc_cfg | output | 8 | Stored cascade configuration |

## Verification
The hardest situation to reach is nested service. A request must be blocked by a higher-priority bit already in service while a still higher-priority request breaks through it. The stimulus acknowledges input 3, holds that request, adds input 5 (which must stay silent), and then adds input 1 (which must raise the output). It then retires the two in-service bits one at a time and reads the in-service register back after each end-of-interrupt command. Reconfiguring with live in-service state shows that configuration wipes that state.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ST_UNCFG = 3'd0,
    ST_BASE  = 3'd1,
    ST_CASC  = 3'd2,
    ST_MODE  = 3'd3,
    ST_RUN   = 3'd4
  } cfg_state_t;

  localparam logic [7:0] CMD_INIT    = 8'h11;
  localparam logic [7:0] CMD_SEL_ISR = 8'h0B;
  localparam logic [7:0] CMD_SEL_IRR = 8'h0A;
  localparam logic [7:0] CMD_EOI     = 8'h60;
  localparam int         MODE_AUTO_BIT = 1;
endpackage

// File: rtl/pic_rst_sync.sv
module pic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int N_IN      = 8,
  parameter bit IS_MASTER = 1'b1,
  localparam int IW = $clog2(N_IN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_cmd,
  input  logic                 wr_dat,
  input  logic [N_IN-1:0]      wdata,
  output logic                 cfg_done,
  output logic                 init_go,
  output logic [N_IN-IW-1:0]   base_hi,
  output logic [N_IN-1:0]      casc,
  output logic                 aeoi,
  output logic [N_IN-1:0]      imr,
  output logic                 sel_isr,
  output logic                 eoi_go,
  output logic [IW-1:0]        eoi_idx
);
  localparam logic [N_IN-IW-1:0] EOI_HI = CMD_EOI[7:IW];

  cfg_state_t           st_q, st_n;
  logic [N_IN-IW-1:0]   base_q, base_n;
  logic [N_IN-1:0]      casc_q, casc_n, casc_fmt;
  logic                 aeoi_q, aeoi_n;
  logic [N_IN-1:0]      imr_q, imr_n;
  logic                 sel_q, sel_n;

  generate
    if (IS_MASTER) begin : g_master
      assign casc_fmt = wdata;
    end else begin : g_slave
      assign casc_fmt = {{(N_IN-IW){1'b0}}, wdata[IW-1:0]};
    end
  endgenerate

  assign init_go = wr_cmd && (wdata == CMD_INIT);
  assign eoi_go  = wr_cmd && (wdata[N_IN-1:IW] == EOI_HI);
  assign eoi_idx = wdata[IW-1:0];

  always_comb begin
    st_n   = st_q;
    base_n = base_q;
    casc_n = casc_q;
    aeoi_n = aeoi_q;
    imr_n  = imr_q;
    sel_n  = sel_q;
    if (init_go) begin
      st_n  = ST_BASE;
      imr_n = '0;
      sel_n = 1'b0;
    end else if (wr_cmd && (wdata == CMD_SEL_ISR)) begin
      sel_n = 1'b1;
    end else if (wr_cmd && (wdata == CMD_SEL_IRR)) begin
      sel_n = 1'b0;
    end
    if (wr_dat) begin
      case (st_q)
        ST_BASE: begin base_n = wdata[N_IN-1:IW]; st_n = ST_CASC; end
        ST_CASC: begin casc_n = casc_fmt;         st_n = ST_MODE; end
        ST_MODE: begin aeoi_n = wdata[MODE_AUTO_BIT]; st_n = ST_RUN; end
        ST_RUN:  imr_n = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_UNCFG;
      base_q <= '0;
      casc_q <= '0;
      aeoi_q <= 1'b0;
      imr_q  <= '1;
      sel_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      base_q <= base_n;
      casc_q <= casc_n;
      aeoi_q <= aeoi_n;
      imr_q  <= imr_n;
      sel_q  <= sel_n;
    end
  end

  assign cfg_done = (st_q == ST_RUN);
  assign base_hi  = base_q;
  assign casc     = casc_q;
  assign aeoi     = aeoi_q;
  assign imr      = imr_q;
  assign sel_isr  = sel_q;
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
  parameter int N_IN      = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [N_IN-1:0] wdata,
  output logic [N_IN-1:0] rdata,
  input  logic [N_IN-1:0] irq_in,
  input  logic            inta,
  output logic            int_out,
  output logic [N_IN-1:0] vector,
  output logic [N_IN-1:0] casc_cfg
);
  localparam int IW = $clog2(N_IN);

  logic                 rst_n_s;
  logic                 cfg_done, init_go, aeoi, sel_isr, eoi_go;
  logic [N_IN-IW-1:0]   base_hi;
  logic [N_IN-1:0]      imr;
  logic [IW-1:0]        eoi_idx;
  logic [N_IN-1:0]      irr_q, isr_q, isr_n, rdata_q, rdata_n, vec_q, vec_n;
  logic [N_IN-1:0]      pend;
  logic                 pend_hit, isr_hit, outrank, grant;
  logic [IW-1:0]        pend_idx, isr_idx;

  pic_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  pic_cfg #(.N_IN(N_IN), .IS_MASTER(IS_MASTER)) u_cfg (
    .clk(clk), .rst_n(rst_n_s),
    .wr_cmd(wr_en && !addr), .wr_dat(wr_en && addr), .wdata(wdata),
    .cfg_done(cfg_done), .init_go(init_go), .base_hi(base_hi),
    .casc(casc_cfg), .aeoi(aeoi), .imr(imr), .sel_isr(sel_isr),
    .eoi_go(eoi_go), .eoi_idx(eoi_idx)
  );

  assign pend = irr_q & ~imr;

  pic_prio #(.N(N_IN)) u_prio_req (.req(pend),  .hit(pend_hit), .idx(pend_idx));
  pic_prio #(.N(N_IN)) u_prio_isr (.req(isr_q), .hit(isr_hit),  .idx(isr_idx));

  assign outrank = pend_hit && (!isr_hit || (pend_idx < isr_idx));
  assign int_out = cfg_done && outrank;
  assign grant   = inta && int_out;

  always_comb begin
    isr_n = isr_q;
    if (init_go) begin
      isr_n = '0;
    end else begin
      if (eoi_go)          isr_n[eoi_idx]  = 1'b0;
      if (grant && !aeoi)  isr_n[pend_idx] = 1'b1;
    end
    vec_n = vec_q;
    if (inta) vec_n = {base_hi, (grant ? pend_idx : {IW{1'b1}})};
    rdata_n = rdata_q;
    if (rd_en) rdata_n = addr ? imr : (sel_isr ? isr_q : irr_q);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      irr_q   <= '0;
      isr_q   <= '0;
      vec_q   <= '0;
      rdata_q <= '0;
    end else begin
      irr_q   <= irq_in;
      isr_q   <= isr_n;
      vec_q   <= vec_n;
      rdata_q <= rdata_n;
    end
  end

  assign vector = vec_q;
  assign rdata  = rdata_q;
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int N_IN = 8,
  localparam int IW = $clog2(N_IN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            inta,
  input logic            int_out,
  input logic            wr_en,
  input logic            addr,
  input logic [N_IN-1:0] wdata,
  input logic [N_IN-1:0] irr,
  input logic [N_IN-1:0] imr,
  input logic [N_IN-1:0] isr,
  input logic            cfg_done,
  input logic            aeoi,
  input logic [N_IN-1:0] vector
);
  assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata == 8'h11) |=> (isr == '0 && imr == '0 && !cfg_done));

  assert_quiet_unconfig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> !int_out);

  assert_masked_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != '0));

  assert_ack_records_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out && !aeoi && !wr_en) |=> ($countones(isr) == $countones($past(isr)) + 1));

  assert_auto_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && aeoi && !wr_en) |=> (isr == $past(isr)));

  assert_eoi_one_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[N_IN-1:IW] == 5'b01100 && !inta) |=>
    (!isr[$past(wdata[IW-1:0])] &&
     ((isr | (N_IN'(1) << $past(wdata[IW-1:0]))) ==
      ($past(isr) | (N_IN'(1) << $past(wdata[IW-1:0]))))));

  assert_spurious_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out && !wr_en) |=> (vector[IW-1:0] == '1 && isr == $past(isr)));

  assert_full_mask_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == '1) |-> !int_out);
endmodule

bind pic_ctrl pic_ctrl_chk #(.N_IN(N_IN)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .inta(inta), .int_out(int_out),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .irr(irr_q), .imr(imr),
  .isr(isr_q), .cfg_done(cfg_done), .aeoi(aeoi), .vector(vector)
);

// File: tb/test_pic_ctrl.sv
`timescale 1ns/1ps
module test_pic_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, addr, wr_en, rd_en, inta;
  logic [7:0] wdata, irq_in;
  logic [7:0] rdata, vector, casc_cfg;
  logic       int_out;
  logic [7:0] s_rdata, s_vector, s_casc;
  logic       s_int;
  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  pic_ctrl #(.N_IN(8), .IS_MASTER(1'b1)) i_pic_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .inta(inta),
    .int_out(int_out), .vector(vector), .casc_cfg(casc_cfg)
  );

  pic_ctrl #(.N_IN(8), .IS_MASTER(1'b0)) i_pic_ctrl_slave (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(s_rdata), .irq_in(irq_in), .inta(inta),
    .int_out(s_int), .vector(s_vector), .casc_cfg(s_casc)
  );

  // {irq_in, mask, expected int_out, expected vector}; base is 0x48
  localparam logic [31:0] TBL [8] = '{
    {8'h01, 8'h00, 8'h01, 8'h48},
    {8'h80, 8'h00, 8'h01, 8'h4F},
    {8'h0C, 8'h00, 8'h01, 8'h4A},
    {8'h0C, 8'h04, 8'h01, 8'h4B},
    {8'hF0, 8'h10, 8'h01, 8'h4D},
    {8'hFF, 8'hFF, 8'h00, 8'h4F},
    {8'h00, 8'h00, 8'h00, 8'h4F},
    {8'h60, 8'h20, 8'h01, 8'h4E}
  };

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ack();
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    rst_n = 1'b0; addr = 1'b0; wr_en = 1'b0; rd_en = 1'b0; inta = 1'b0;
    wdata = 8'h00; irq_in = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 vector after reset", vector, 8'h00);
    chk("R1 int_out after reset", {7'b0, int_out}, 8'h00);
    rd(1'b1, rv); chk("R1 mask after reset", rv, 8'hFF);
    irq_in = 8'h04; settle();
    rd(1'b0, rv); chk("R1 R12 request read", rv, 8'h04);
    chk("R3 int_out before config", {7'b0, int_out}, 8'h00);
    wr(1'b1, 8'h00);
    rd(1'b1, rv); chk("R3 data write ignored", rv, 8'hFF);

    wr(1'b0, 8'h11); wr(1'b1, 8'h48); wr(1'b1, 8'h0B);
    chk("R3 int_out mid config", {7'b0, int_out}, 8'h00);
    wr(1'b1, 8'h00);
    chk("R4 master cascade", casc_cfg, 8'h0B);
    chk("R4 slave cascade", s_casc, 8'h03);
    rd(1'b1, rv); chk("R2 mask cleared", rv, 8'h00);
    chk("R3 int_out after config", {7'b0, int_out}, 8'h01);
    irq_in = 8'h00; settle();
    chk("R12 request removed", {7'b0, int_out}, 8'h00);

    for (int k = 0; k < 8; k++) begin
      logic [31:0] e;
      e = TBL[k];
      wr(1'b1, e[23:16]);
      irq_in = e[31:24]; settle();
      chk("R7 R13 int_out", {7'b0, int_out}, e[15:8]);
      ack();
      chk("R8 R11 vector", vector, e[7:0]);
      wr(1'b0, 8'h0B);
      rd(1'b0, rv);
      chk("R8 R11 in-service", rv, e[8] ? (8'h01 << e[2:0]) : 8'h00);
      if (e[8]) begin
        wr(1'b0, 8'h60 | {5'b0, e[2:0]});
        rd(1'b0, rv); chk("R10 eoi clears", rv, 8'h00);
      end
      irq_in = 8'h00;
    end

    wr(1'b1, 8'h00);
    irq_in = 8'h08; settle();
    ack();
    irq_in = 8'h28; settle();
    chk("R7 lower priority blocked", {7'b0, int_out}, 8'h00);
    irq_in = 8'h2A; settle();
    chk("R7 higher priority nests", {7'b0, int_out}, 8'h01);
    ack();
    chk("R8 nested vector", vector, 8'h49);
    rd(1'b0, rv); chk("R8 nested in-service", rv, 8'h0A);
    wr(1'b0, 8'h61);
    rd(1'b0, rv); chk("R10 only bit 1 cleared", rv, 8'h08);
    wr(1'b0, 8'h63);
    rd(1'b0, rv); chk("R10 bit 3 cleared", rv, 8'h00);

    irq_in = 8'h55;
    wr(1'b0, 8'h0A);
    rd(1'b0, rv); chk("R6 request select", rv, 8'h55);
    wr(1'b0, 8'h0B);
    rd(1'b0, rv); chk("R6 in-service select", rv, 8'h00);

    irq_in = 8'h01; settle();
    ack();
    rd(1'b0, rv); chk("R8 in-service before reconfig", rv, 8'h01);
    irq_in = 8'h00;
    wr(1'b0, 8'h11); wr(1'b1, 8'h48); wr(1'b1, 8'h0B); wr(1'b1, 8'h02);
    wr(1'b0, 8'h0B);
    rd(1'b0, rv); chk("R2 in-service cleared", rv, 8'h00);
    irq_in = 8'h10; settle();
    chk("R9 int_out", {7'b0, int_out}, 8'h01);
    ack();
    chk("R9 vector", vector, 8'h4C);
    rd(1'b0, rv); chk("R9 no in-service bit", rv, 8'h00);
    chk("R9 R12 level stays asserted", {7'b0, int_out}, 8'h01);
    wr(1'b1, 8'hFF); settle();
    chk("R13 full mask", {7'b0, int_out}, 8'h00);

    report();
  end
endmodule